// File: doc/BRIEF.md
# INT8 Tensor Dot-Product Accumulator

This block is a pipelined integer tensor unit. In every cycle that an input vector is marked valid, it multiplies twenty pairs of signed 8-bit operands. The twenty lanes form two columns of ten. Each column sums its ten products in a registered adder tree, adds a 32-bit cascade value from an upstream unit, and then either loads the result into its own 32-bit accumulator or adds it to the value already there.

Each column's accumulator drives the result port and also the cascade output, so several units can be chained into longer dot products. A shared block exponent comes in with each operand vector. It travels through the pipeline and appears at the output together with the integer result, so that a later stage can rescale the block as a block-floating value. Arithmetic is two's complement and wraps without saturation.

Top module: `tdot_accum`

## Requirements
- R1: An active-high synchronous reset `rst` clears `out_valid`, `res`, `cas_out` and `exp_out` to zero and discards every vector still in the pipeline.
- R2: `out_valid` is high exactly three cycles after a cycle in which `in_valid` was sampled high, and it pulses once for each valid input.
- R3: Lane i occupies bits [8i+7:8i] of `a_vec` and `b_vec`. Both operands are signed. Lanes 0 to 9 feed column 0 and lanes 10 to 19 feed column 1. Column c appears at `res` bits [32c+31:32c] and takes its cascade from `cas_in` at the same position. With neither `acc_clr` nor `acc_en` set, a column's result is its ten-product sum plus its cascade input.
- R4: `acc_clr` set with `in_valid` loads the column sum plus cascade input and discards the previous accumulator value. `acc_clr` takes priority over `acc_en`.
- R5: `acc_en` set with `in_valid` (and `acc_clr` low) adds the column sum plus cascade input to the previous accumulator value.
- R6: Accumulation wraps modulo 2^32 in two's complement, with no saturation.
- R7: `cas_out` carries the same value as `res` for each column in every cycle.
- R8: `exp_out` is the `blk_exp` that came with the input whose result is on `res`. It updates in the cycle `out_valid` is high.
- R9: In cycles where `in_valid` is low, `acc_en`, `acc_clr`, the operands and the cascade input have no effect. `res`, `cas_out` and `exp_out` keep their values.
- R10: The two columns are independent: each uses only its own lanes, its own cascade slice and its own accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand vector valid strobe |
| acc_en | input | 1 | Add to the stored accumulator value |
| acc_clr | input | 1 | Load the accumulator and discard the prior value |
| a_vec | input | 160 | Twenty signed 8-bit A operands |
| b_vec | input | 160 | Twenty signed 8-bit B operands |
| blk_exp | input | 8 | Shared block exponent of the vector |
| cas_in | input | 64 | Cascade input, 32 bits per column |
| out_valid | output | 1 | Result valid |
| res | output | 64 | Column results, 32 bits per column |
| cas_out | output | 64 | Cascade output to the downstream unit |
| exp_out | output | 8 | Exponent aligned with the result |

## Verification
Each result, its exponent and its `out_valid` pulse are due three rising edges after the edge that samples the valid input: one edge for the product registers, one for the tree sum and one for the accumulator. The bench drives each vector on a falling edge. It computes the expected column values at that moment and pushes them into a three-entry history. On every later falling edge it compares the outputs with the oldest entry, so all checks happen midway between edges and exactly on the cycle the result is due. Idle entries carry the last expected values, which checks that the outputs hold between valid cycles.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

    localparam int DEF_OP_W  = 8;
    localparam int DEF_LANES = 10;
    localparam int DEF_COLS  = 2;
    localparam int DEF_ACC_W = 32;
    localparam int DEF_EXP_W = 8;

    // What the accumulator does with a valid column total
    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_ADD  = 2'd2
    } acc_mode_e;

    // Per-stage control that travels beside the datapath
    typedef struct packed {
        logic      valid;
        acc_mode_e mode;
    } ctl_t;

    // clear wins over accumulate
    function automatic acc_mode_e pick_mode(input logic clr, input logic acc);
        if (clr)      return MODE_LOAD;
        else if (acc) return MODE_ADD;
        else          return MODE_PASS;
    endfunction

    // levels of a binary reduction tree for n leaves
    function automatic int tree_depth(input int n);
        int d;
        d = 0;
        while ((1 << d) < n) d++;
        return d;
    endfunction

endpackage

// File: rtl/tdot_mul_stage.sv
module tdot_mul_stage #(
    parameter int LANES = tdot_pkg::DEF_LANES,
    parameter int OP_W  = tdot_pkg::DEF_OP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LANES*OP_W-1:0]      a_in,
    input  logic [LANES*OP_W-1:0]      b_in,
    output logic [LANES*2*OP_W-1:0]    prod_q
);
    localparam int PW = 2 * OP_W;

    logic [LANES*PW-1:0] prod_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [PW-1:0] ea;
        logic signed [PW-1:0] eb;
        assign ea = {{OP_W{a_in[i*OP_W+OP_W-1]}}, a_in[i*OP_W +: OP_W]};
        assign eb = {{OP_W{b_in[i*OP_W+OP_W-1]}}, b_in[i*OP_W +: OP_W]};
        // full signed product fits in PW bits
        assign prod_d[i*PW +: PW] = ea * eb;
    end

    always_ff @(posedge clk) begin
        if (rst) prod_q <= '0;
        else     prod_q <= prod_d;
    end

endmodule

// File: rtl/tdot_add_tree.sv
module tdot_add_tree #(
    parameter int N     = tdot_pkg::DEF_LANES,
    parameter int IN_W  = 2 * tdot_pkg::DEF_OP_W,
    parameter int OUT_W = tdot_pkg::DEF_ACC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N*IN_W-1:0]    terms,
    output logic [OUT_W-1:0]     sum_q
);
    localparam int D     = tdot_pkg::tree_depth(N);
    localparam int P     = 1 << D;
    localparam int NODES = 2 * P - 1;

    // heap layout: root at 0, children of k at 2k+1 and 2k+2, leaves from P-1
    logic signed [OUT_W-1:0] node [NODES];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_used
            assign node[P-1+i] = OUT_W'(signed'(terms[i*IN_W +: IN_W]));
        end else begin : g_pad
            assign node[P-1+i] = '0;
        end
    end

    for (genvar k = 0; k < P - 1; k++) begin : g_add
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    always_ff @(posedge clk) begin
        if (rst) sum_q <= '0;
        else     sum_q <= node[0];
    end

endmodule

// File: rtl/tdot_col_acc.sv
module tdot_col_acc #(
    parameter int ACC_W = tdot_pkg::DEF_ACC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  tdot_pkg::acc_mode_e  mode,
    input  logic [ACC_W-1:0]     sum_in,
    input  logic [ACC_W-1:0]     cas_in,
    output logic [ACC_W-1:0]     acc_q
);
    import tdot_pkg::*;

    logic [ACC_W-1:0] total;
    assign total = sum_in + cas_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (v_in) begin
            unique case (mode)
                MODE_ADD: acc_q <= acc_q + total;
                default:  acc_q <= total;
            endcase
        end
    end

    a_r4_clear_load: assert property (@(posedge clk) disable iff (rst)
        (v_in && mode == MODE_LOAD) |=> acc_q == ACC_W'($past(sum_in) + $past(cas_in)));

    a_r5_accum_add: assert property (@(posedge clk) disable iff (rst)
        (v_in && mode == MODE_ADD) |=>
            acc_q == ACC_W'($past(acc_q) + $past(sum_in) + $past(cas_in)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(acc_q));

endmodule

// File: rtl/tdot_accum.sv
module tdot_accum #(
    parameter int COLS          = tdot_pkg::DEF_COLS,
    parameter int LANES_PER_COL = tdot_pkg::DEF_LANES,
    parameter int OP_W          = tdot_pkg::DEF_OP_W,
    parameter int ACC_W         = tdot_pkg::DEF_ACC_W,
    parameter int EXP_W         = tdot_pkg::DEF_EXP_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic                                 acc_en,
    input  logic                                 acc_clr,
    input  logic [COLS*LANES_PER_COL*OP_W-1:0]   a_vec,
    input  logic [COLS*LANES_PER_COL*OP_W-1:0]   b_vec,
    input  logic [EXP_W-1:0]                     blk_exp,
    input  logic [COLS*ACC_W-1:0]                cas_in,
    output logic                                 out_valid,
    output logic [COLS*ACC_W-1:0]                res,
    output logic [COLS*ACC_W-1:0]                cas_out,
    output logic [EXP_W-1:0]                     exp_out
);
    import tdot_pkg::*;

    localparam int COL_OPS = LANES_PER_COL * OP_W;
    localparam int PW      = 2 * OP_W;

    // control and exponent pipeline, aligned with product and tree stages
    ctl_t             ctl1, ctl2;
    logic [EXP_W-1:0] exp1, exp2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1      <= '0;
            ctl2      <= '0;
            exp1      <= '0;
            exp2      <= '0;
            exp_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            ctl1.valid <= in_valid;
            ctl1.mode  <= pick_mode(acc_clr, acc_en);
            exp1       <= blk_exp;
            ctl2       <= ctl1;
            exp2       <= exp1;
            out_valid  <= ctl2.valid;
            if (ctl2.valid) exp_out <= exp2;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [LANES_PER_COL*PW-1:0] prod;
        logic [ACC_W-1:0]            col_sum;
        logic [ACC_W-1:0]            cas1, cas2;
        logic [ACC_W-1:0]            acc;

        always_ff @(posedge clk) begin
            if (rst) begin
                cas1 <= '0;
                cas2 <= '0;
            end else begin
                cas1 <= cas_in[c*ACC_W +: ACC_W];
                cas2 <= cas1;
            end
        end

        tdot_mul_stage #(.LANES(LANES_PER_COL), .OP_W(OP_W)) u_mul (
            .clk   (clk),
            .rst   (rst),
            .a_in  (a_vec[c*COL_OPS +: COL_OPS]),
            .b_in  (b_vec[c*COL_OPS +: COL_OPS]),
            .prod_q(prod)
        );

        tdot_add_tree #(.N(LANES_PER_COL), .IN_W(PW), .OUT_W(ACC_W)) u_tree (
            .clk  (clk),
            .rst  (rst),
            .terms(prod),
            .sum_q(col_sum)
        );

        tdot_col_acc #(.ACC_W(ACC_W)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .v_in  (ctl2.valid),
            .mode  (ctl2.mode),
            .sum_in(col_sum),
            .cas_in(cas2),
            .acc_q (acc)
        );

        assign res[c*ACC_W +: ACC_W]     = acc;
        assign cas_out[c*ACC_W +: ACC_W] = acc;
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    a_r8_exp_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl2.valid |=> $stable(exp_out));

    a_r9_res_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl2.valid |=> $stable(res));

endmodule

// File: tb/tdot_accum_test.sv
`timescale 1ns/1ps
module tdot_accum_test;
    localparam int L  = 10;
    localparam int C  = 2;
    localparam int N  = L * C;
    localparam int W  = 8;
    localparam int AW = 32;
    localparam int EW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              in_valid = 1'b0, acc_en = 1'b0, acc_clr = 1'b0;
    logic [N*W-1:0]    a_vec = '0, b_vec = '0;
    logic [EW-1:0]     blk_exp = '0;
    logic [C*AW-1:0]   cas_in = '0;
    logic              out_valid;
    logic [C*AW-1:0]   res, cas_out;
    logic [EW-1:0]     exp_out;

    tdot_accum uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_en(acc_en), .acc_clr(acc_clr),
        .a_vec(a_vec), .b_vec(b_vec), .blk_exp(blk_exp), .cas_in(cas_in),
        .out_valid(out_valid), .res(res), .cas_out(cas_out), .exp_out(exp_out)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit          v;
        logic [AW-1:0] r0, r1;
        logic [EW-1:0] e;
        string       tag;
    } exp_t;

    exp_t          h [3];
    logic [AW-1:0] m_acc [2];
    logic [EW-1:0] m_exp;

    function automatic logic [AW-1:0] col_sum(input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                                              input int c);
        int s;
        s = 0;
        for (int i = 0; i < L; i++) begin
            int pa, pb;
            pa = int'($signed(a[(c*L+i)*W +: W]));
            pb = int'($signed(b[(c*L+i)*W +: W]));
            s += pa * pb;
        end
        return AW'(s);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 3; i++) begin
            h[i].v = 0; h[i].r0 = '0; h[i].r1 = '0; h[i].e = '0; h[i].tag = "R1";
        end
        m_acc[0] = '0; m_acc[1] = '0; m_exp = '0;
    endtask

    task automatic compare_outputs();
        chk("R2 out_valid", 64'(out_valid), 64'(h[2].v));
        chk({h[2].tag, " res col0"}, 64'(res[AW-1:0]), 64'(h[2].r0));
        chk({h[2].tag, " R10 res col1"}, 64'(res[2*AW-1:AW]), 64'(h[2].r1));
        chk("R7 cas_out", 64'(cas_out), {h[2].r1, h[2].r0});
        chk("R8 exp_out", 64'(exp_out), 64'(h[2].e));
    endtask

    task automatic cyc(input bit v, input bit clr, input bit acc,
                       input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                       input logic [EW-1:0] e, input logic [C*AW-1:0] cs, input string tag);
        exp_t ent;
        @(negedge clk);
        compare_outputs();
        h[2] = h[1];
        h[1] = h[0];
        in_valid = v; acc_clr = clr; acc_en = acc;
        a_vec = a; b_vec = b; blk_exp = e; cas_in = cs;
        if (v) begin
            for (int c = 0; c < C; c++) begin
                logic [AW-1:0] s;
                s = col_sum(a, b, c) + cs[c*AW +: AW];
                if (clr)      m_acc[c] = s;
                else if (acc) m_acc[c] = m_acc[c] + s;
                else          m_acc[c] = s;
            end
            m_exp = e;
        end
        ent.v = v; ent.r0 = m_acc[0]; ent.r1 = m_acc[1]; ent.e = m_exp;
        ent.tag = v ? tag : "R9";
        h[0] = ent;
    endtask

    function automatic logic [N*W-1:0] rnd_vec();
        logic [N*W-1:0] x;
        for (int i = 0; i < N; i++) x[i*W +: W] = W'($urandom);
        return x;
    endfunction

    function automatic logic [C*AW-1:0] rnd_cas();
        return {32'($urandom), 32'($urandom)};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, '0, '0, '0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset res", 64'(res), 64'd0);
        chk("R1 reset cas_out", 64'(cas_out), 64'd0);
        chk("R1 reset exp_out", 64'(exp_out), 64'd0);
        rst = 1'b0;

        // all lanes at the most negative operand
        cyc(1, 1, 0, {N{8'h80}}, {N{8'h80}}, 8'h05, '0, "R3");
        cyc(1, 0, 1, {N{8'h80}}, {N{8'h80}}, 8'h06, '0, "R5");
        // controls without valid must do nothing
        cyc(0, 1, 1, rnd_vec(), rnd_vec(), 8'hEE, rnd_cas(), "R9");
        cyc(0, 0, 1, rnd_vec(), rnd_vec(), 8'hDD, rnd_cas(), "R9");
        idle(2);
        cyc(1, 0, 1, rnd_vec(), rnd_vec(), 8'h07, {32'd100, 32'hFFFF_FF00}, "R10");
        idle(3);
        // wrap across the signed boundary
        cyc(1, 1, 0, '0, '0, 8'h10, {32'h0, 32'h7FFF_FFFF}, "R6");
        cyc(1, 0, 1, '0, '0, 8'h11, {32'h1, 32'h1}, "R6");
        cyc(1, 0, 1, {N{8'h7F}}, {N{8'h7F}}, 8'h12, {32'hFFFF_FFFF, 32'h8000_0000}, "R6");
        // clear and accumulate together: clear wins
        cyc(1, 1, 1, rnd_vec(), rnd_vec(), 8'h20, rnd_cas(), "R4");
        cyc(1, 0, 0, rnd_vec(), rnd_vec(), 8'h21, rnd_cas(), "R3");
        idle(3);

        for (int i = 0; i < 400; i++) begin
            bit v, clr, acc;
            string tag;
            v   = ($urandom % 4) != 0;
            clr = ($urandom % 5) == 0;
            acc = ($urandom % 2) == 1;
            tag = clr ? "R4" : (acc ? "R5" : "R3");
            cyc(v, clr, acc, rnd_vec(), rnd_vec(), EW'($urandom), rnd_cas(), tag);
        end

        // reset while vectors are in flight
        cyc(1, 1, 0, rnd_vec(), rnd_vec(), 8'h33, rnd_cas(), "R4");
        cyc(1, 0, 1, rnd_vec(), rnd_vec(), 8'h34, rnd_cas(), "R5");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; acc_en = 1'b0; acc_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 midrun out_valid", 64'(out_valid), 64'd0);
        chk("R1 midrun res", 64'(res), 64'd0);
        chk("R1 midrun cas_out", 64'(cas_out), 64'd0);
        chk("R1 midrun exp_out", 64'(exp_out), 64'd0);
        rst = 1'b0;
        clear_model();
        repeat (4) @(negedge clk);
        chk("R1 no stale result", 64'(out_valid), 64'd0);

        cyc(1, 0, 1, rnd_vec(), rnd_vec(), 8'h44, rnd_cas(), "R5");
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule